// File: doc/BRIEF.md
# Multi-channel event timer with comparators

The block keeps a free-running 64-bit main counter and a small set of comparator channels. It is programmed over a simple register bus with single-cycle writes and combinational reads. Each channel compares the low 32 bits of the counter with its own comparator. When they are equal, the channel latches an interrupt status bit. A channel runs either one-shot or periodic. In periodic mode, every match adds a stored period to the comparator.

A channel config bit arms a two-step load on the comparator register. The first comparator write after arming sets the comparator, and the second sets the period. A global routing switch moves the status of channels 0 and 1 off the ordinary interrupt outputs and onto two fixed legacy lines: a system tick line and a real-time-clock line.

Register offsets (byte addresses): ID 0x000, tick period 0x004, global config 0x010, interrupt status 0x020, counter low 0x0F0, counter high 0x0F4. Channel n sits at 0x100 + 0x20·n, with its config at +0x0 and its comparator at +0x8. Unmapped addresses read as zero.

Top module: `evt_timer_top`

## Requirements
- R1: The main counter increases by exactly one per clock while global config bit 0 (run) is 1 and holds its value while that bit is 0.
- R2: While run is 0, writes to 0x0F0 load counter bits 31:0 and writes to 0x0F4 load counter bits 63:32. While run is 1, such writes are ignored. Both halves read back at those offsets.
- R3: With global config bit 1 (legacy routing) set, `legacy_tick_o` follows channel 0 status, `legacy_rtc_o` follows channel 1 status, and `irq_o[0]` and `irq_o[1]` stay 0. With the bit clear, both legacy lines are 0 and `irq_o[n]` follows the status of channel n.
- R4: Writing 1 to channel config bit 6 arms a sequence: the next comparator write sets the comparator and the one after sets the period. Bit 6 reads 1 until the second write completes and 0 afterwards. A comparator write when not armed sets only the comparator.
- R5: With channel config bit 3 (periodic) set, each match adds the stored period to the comparator, so the comparator steps through A, A+P, A+2P, and so on.
- R6: A channel with config bit 2 (enable) set and bit 3 clear latches status once, when the counter reaches the comparator. With bit 2 clear, the channel never latches status.
- R7: The status register at 0x020 holds one bit per channel (bit n for channel n). Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: The ID register reads the channel count minus one in bits 12:8 and a 1 in bit 15, which marks legacy routing as supported.
- R9: The register at 0x004 is read-only and returns the tick period in femtoseconds given by parameter `TICK_FS`.
- R10: For channels 2 and above, config bits 13:9 hold a route field that reads back as written. For channels 0 and 1, those bits read 0. Config bit 8 (32-bit hint) reads back on every channel.
- R11: Matching uses only the low 32 bits of the counter, whatever the value of bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | NUM_CH | Per-channel interrupt level |
| legacy_tick_o | output | 1 | Channel 0 status when legacy routing is on |
| legacy_rtc_o | output | 1 | Channel 1 status when legacy routing is on |

## Verification
The bench builds the block with four channels, not the default three. This gives two channels that carry a route field, so the stored field and its absence on channels 0 and 1 are both observable. Periodic runs use small random comparator starts, periods and run lengths. Each run therefore crosses several reloads, and the final comparator can be predicted from the counter value that is read back. The high counter half is preloaded with a nonzero value before a one-shot match, which exposes any comparison that looks beyond the low 32 bits.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [11:0] A_ID    = 12'h000;
  localparam logic [11:0] A_TICK  = 12'h004;
  localparam logic [11:0] A_GCFG  = 12'h010;
  localparam logic [11:0] A_STAT  = 12'h020;
  localparam logic [11:0] A_CNTLO = 12'h0F0;
  localparam logic [11:0] A_CNTHI = 12'h0F4;
  localparam int          CH_BLK0 = 8;     // channel blocks start at 0x100, 32 bytes each
  localparam logic [4:0]  CH_CFG  = 5'h00;
  localparam logic [4:0]  CH_CMP  = 5'h08;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_VAL, SEQ_PER} seq_t;

  function automatic logic [31:0] next_cmp(input logic [31:0] cmp, input logic [31:0] per);
    return cmp + per;
  endfunction

  function automatic logic [31:0] id_word(input int nch, input bit leg_cap);
    logic [31:0] w;
    w = '0;
    w[12:8] = 5'(nch - 1);
    w[15] = leg_cap;
    return w;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else if (wr_lo) cnt[31:0] <= wdata;
    else if (wr_hi) cnt[CW-1:32] <= wdata[CW-33:0];
  end

  AST_RUN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 1'b1); // R1
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt)); // R1
  AST_LO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_lo) |=> cnt[31:0] == $past(wdata)); // R2
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit HAS_ROUTE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cnt_lo,
  input  logic        run,
  input  logic        cfg_we,
  input  logic        cmp_we,
  input  logic [31:0] wdata,
  input  logic        st_clr,
  output logic [31:0] cfg_q,
  output logic [31:0] cmp_q,
  output logic        status_q,
  output logic        hit
);
  logic        en_q, per_q, wide_q;
  logic [4:0]  route_q;
  logic [31:0] period_q;
  seq_t        seq_q;

  assign hit = run && en_q && (cnt_lo == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; per_q <= 1'b0; wide_q <= 1'b0; route_q <= '0;
      seq_q <= SEQ_IDLE; cmp_q <= '1; period_q <= '0;
    end else if (cfg_we) begin
      en_q   <= wdata[2];
      per_q  <= wdata[3];
      wide_q <= wdata[8];
      if (HAS_ROUTE) route_q <= wdata[13:9];
      if (wdata[6]) seq_q <= SEQ_VAL;
    end else if (cmp_we) begin
      unique case (seq_q)
        SEQ_VAL: begin cmp_q <= wdata; seq_q <= SEQ_PER; end
        SEQ_PER: begin period_q <= wdata; seq_q <= SEQ_IDLE; end
        default: cmp_q <= wdata;
      endcase
    end else if (hit && per_q) begin
      cmp_q <= next_cmp(cmp_q, period_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else if (hit) status_q <= 1'b1;
    else if (st_clr) status_q <= 1'b0;
  end

  assign cfg_q = {18'b0, route_q, wide_q, 1'b0, seq_q != SEQ_IDLE, 2'b0, per_q, en_q, 2'b0};

  AST_SEQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_PER && cmp_we && !cfg_we) |=> seq_q == SEQ_IDLE); // R4
  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && !cfg_we && !cmp_we) |=> cmp_q == $past(cmp_q) + $past(period_q)); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit); // R6
  AST_HIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !hit) |=> !status_q); // R7
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter logic [31:0] TICK_FS = 32'd69841279
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic              legacy_tick_o,
  output logic              legacy_rtc_o
);
  localparam int CW = 64;

  logic          run_q, leg_q;
  logic [CW-1:0] cnt;
  logic [NUM_CH-1:0] st_v, hit_v;
  logic [31:0]   cfg_v [NUM_CH];
  logic [31:0]   cmp_v [NUM_CH];

  wire stat_wr = bus_we && (bus_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; leg_q <= 1'b0;
    end else if (bus_we && bus_addr == A_GCFG) begin
      run_q <= bus_wdata[0]; leg_q <= bus_wdata[1];
    end
  end

  evt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .wr_lo(bus_we && bus_addr == A_CNTLO),
    .wr_hi(bus_we && bus_addr == A_CNTHI),
    .wdata(bus_wdata), .cnt(cnt)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    wire sel = (bus_addr[11:5] == 7'(CH_BLK0 + n));
    evt_channel #(.HAS_ROUTE(n >= 2)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_lo(cnt[31:0]), .run(run_q),
      .cfg_we(bus_we && sel && bus_addr[4:0] == CH_CFG),
      .cmp_we(bus_we && sel && bus_addr[4:0] == CH_CMP),
      .wdata(bus_wdata), .st_clr(stat_wr && bus_wdata[n]),
      .cfg_q(cfg_v[n]), .cmp_q(cmp_v[n]), .status_q(st_v[n]), .hit(hit_v[n])
    );
    if (n < 2) begin : g_leg
      assign irq_o[n] = st_v[n] && !leg_q;
    end else begin : g_std
      assign irq_o[n] = st_v[n];
    end
  end

  assign legacy_tick_o = leg_q && st_v[0];
  assign legacy_rtc_o  = leg_q && st_v[1];

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_ID:    bus_rdata = id_word(NUM_CH, 1'b1);
      A_TICK:  bus_rdata = TICK_FS;
      A_GCFG:  bus_rdata = {30'b0, leg_q, run_q};
      A_STAT:  bus_rdata = 32'(st_v);
      A_CNTLO: bus_rdata = cnt[31:0];
      A_CNTHI: bus_rdata = cnt[63:32];
      default: begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (bus_addr[11:5] == 7'(CH_BLK0 + n)) begin
            if (bus_addr[4:0] == CH_CFG) bus_rdata = cfg_v[n];
            else if (bus_addr[4:0] == CH_CMP) bus_rdata = cmp_v[n];
          end
        end
      end
    endcase
  end

  AST_LEG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_q && st_v[0]) |-> (legacy_tick_o && !irq_o[0])); // R3
  AST_LEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !leg_q |-> (!legacy_tick_o && !legacy_rtc_o)); // R3
  AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_v[0]) |-> $past(hit_v[0])); // R6
endmodule

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;
  localparam int NCH = 4;
  localparam logic [31:0] TFS = 32'd69841279;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] irq_o;
  logic legacy_tick_o, legacy_rtc_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_timer_top #(.NUM_CH(NCH), .TICK_FS(TFS)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .legacy_tick_o(legacy_tick_o), .legacy_rtc_o(legacy_rtc_o)
  );

  function automatic logic [11:0] cha(input int n, input int off);
    return 12'(12'h100 + n * 32 + off);
  endfunction

  // comparator after periodic hits on counter values 0..c-1
  function automatic logic [31:0] exp_cmp(input logic [31:0] a, input logic [31:0] p, input logic [31:0] c);
    logic [31:0] v = a;
    while (v < c) v = v + p;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int m);
    repeat (m) @(negedge clk);
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, a, p, c, d2;
    int m;
    void'($urandom(32'd1234));
    idle(3); rst_n = 1'b1; @(negedge clk);

    rd(12'h000, d); chk("R8 id", d, 32'((NCH - 1) << 8) | 32'h8000);
    rd(12'h004, d); chk("R9 tick period", d, TFS);
    wr(12'h004, 32'h0);
    rd(12'h004, d); chk("R9 read-only", d, TFS);
    rd(12'h0F0, d); chk("R1 reset counter", d, 0);
    rd(12'h020, d); chk("R7 reset status", d, 0);

    // R2 counter load while stopped, R1 hold while stopped
    wr(12'h0F0, 32'h100); wr(12'h0F4, 32'h5);
    idle(5);
    rd(12'h0F0, d); chk("R1 stopped hold", d, 32'h100);
    rd(12'h0F4, d); chk("R2 high half", d, 32'h5);
    // R1 runs M+1 edges; R2 write while running ignored
    wr(12'h010, 32'h1); idle(4);
    wr(12'h0F0, 32'hABCD); idle(4);
    wr(12'h010, 32'h0);
    rd(12'h0F0, d); chk("R2 running write ignored / R1 count", d, 32'h100 + 10);

    // R6 one-shot on ch0, R11 with high half nonzero
    wr(12'h0F0, 32'h0); wr(cha(0, 0), 32'h4); wr(cha(0, 8), 32'd20);
    wr(12'h020, 32'hF);
    wr(12'h010, 32'h1); idle(5);
    rd(12'h020, d); chk("R6 before match", d & 1, 0);
    idle(30);
    rd(12'h020, d); chk("R11 low-half match", d & 1, 1);
    chk("R3 irq without legacy", 32'(irq_o[0]), 1);
    chk("R3 legacy line quiet", 32'(legacy_tick_o), 0);
    wr(12'h020, 32'h0);
    rd(12'h020, d); chk("R7 write 0 keeps", d & 1, 1);
    wr(12'h020, 32'h1);
    rd(12'h020, d); chk("R7 write 1 clears", d & 1, 0);
    idle(40);
    rd(12'h020, d); chk("R6 fires once", d & 1, 0);
    rd(12'h0F4, d); chk("R11 high half untouched", d, 32'h5);

    // R3 legacy routing
    wr(12'h010, 32'h0); wr(12'h0F0, 32'h0); wr(cha(0, 8), 32'd3);
    wr(12'h010, 32'h3); idle(10);
    chk("R3 tick line", 32'(legacy_tick_o), 1);
    chk("R3 irq0 masked", 32'(irq_o[0]), 0);
    chk("R3 rtc line idle", 32'(legacy_rtc_o), 0);
    wr(12'h010, 32'h1);
    chk("R3 routing off", {30'b0, legacy_tick_o, irq_o[0]}, 32'h1);

    // R6 disabled channel never latches
    wr(12'h010, 32'h0); wr(12'h0F0, 32'h0); wr(12'h020, 32'hF);
    wr(cha(0, 0), 32'h0); wr(cha(0, 8), 32'd5);
    wr(12'h010, 32'h1); idle(20);
    rd(12'h020, d); chk("R6 disabled", d & 1, 0);
    wr(12'h010, 32'h0);

    // R10 route field
    wr(cha(2, 0), (32'h15 << 9) | 32'h100);
    rd(cha(2, 0), d); chk("R10 route kept", d, (32'h15 << 9) | 32'h100);
    wr(cha(0, 0), (32'h15 << 9) | 32'h100);
    rd(cha(0, 0), d); chk("R10 no route ch0", d, 32'h100);
    wr(cha(0, 0), 32'h0);

    // R4 plain comparator write
    wr(cha(3, 8), 32'h77);
    rd(cha(3, 8), d); chk("R4 plain cmp write", d, 32'h77);

    // R4/R5/R1 random periodic runs on channels 1..3
    for (int i = 0; i < 24; i++) begin
      int ch = 1 + (i % 3);
      a = 32'($urandom_range(1, 50));
      p = 32'($urandom_range(1, 16));
      m = $urandom_range(0, 80);
      wr(12'h010, 32'h0); wr(12'h0F0, 32'h0); wr(12'h0F4, 32'h0);
      wr(cha(ch, 0), 32'h4C);
      rd(cha(ch, 0), d); chk("R4 armed", (d >> 6) & 1, 1);
      wr(cha(ch, 8), a);
      rd(cha(ch, 0), d); chk("R4 still armed", (d >> 6) & 1, 1);
      wr(cha(ch, 8), p);
      rd(cha(ch, 0), d); chk("R4 disarmed", (d >> 6) & 1, 0);
      rd(cha(ch, 8), d); chk("R4 first write is comparator", d, a);
      wr(12'h010, 32'h1); idle(m);
      wr(12'h010, 32'h0);
      rd(12'h0F0, c); chk("R1 run length", c, 32'(m + 1));
      rd(cha(ch, 8), d2); chk("R5 periodic comparator", d2, exp_cmp(a, p, c));
      wr(cha(ch, 0), 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule